// File: doc/BRIEF.md
# ATM Forward Monitoring Cell Inserter

This block sits in the transmit path of one ATM connection. Cells move through it on a bus as wide as one cell payload, with valid/ready handshakes on both sides. User cells pass through untouched and in order. After each block of `BLOCK_CELLS` user cells, the block adds one monitoring cell to the stream before the next user cell. The output flag `out_mon` marks that cell.

The monitoring cell carries three fields:
- the running total of user cells sent on the connection, modulo 2^`CNT_W`;
- a timestamp taken from a free-running cycle counter when the cell enters the output register;
- a bit-interleaved parity word over the payloads of the block just completed.

The parity word restarts from zero after each insertion. Upstream is refused (`in_ready` low) for one cell slot while the monitoring cell takes the output register. Header and HEC generation are left to downstream logic.

Top module: `atm_fm_inserter`

## Requirements
- R1: While reset is asserted and directly after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Every accepted user cell appears on `out_data` with its payload unchanged and `out_mon` = 0. User cells leave in the order they were accepted.
- R3: After every `BLOCK_CELLS` user cells, exactly one cell with `out_mon` = 1 is emitted. No further user cell leaves before it, and no cell is lost or duplicated.
- R4: The count field, `out_data[CNT_W-1:0]` of a monitoring cell, equals the total number of user cells accepted since reset, modulo 2^`CNT_W`. Successive monitoring cells therefore step by `BLOCK_CELLS`.
- R5: The parity field, `out_data[CNT_W+TS_W +: 16]`, is the XOR of all 16-bit words `payload[16i+15:16i]` of the block's user cells. Each block starts from zero.
- R6: The timestamp field, `out_data[CNT_W +: TS_W]`, equals the number of clock edges since reset release, taken before the edge that loads the cell. This is modulo 2^`TS_W`.
- R7: With `out_ready` held at 1, `in_ready` drops for exactly one cycle after the last cell of each block is accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and keeps `out_data` and `out_mon` unchanged.
- R9: All bits of a monitoring cell above the parity field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream cell present |
| in_ready | output | 1 | Block takes the upstream cell this cycle |
| in_data | input | PAY_BYTES*8 | Upstream cell payload |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream takes the output cell |
| out_data | output | PAY_BYTES*8 | Output cell payload or monitoring fields |
| out_mon | output | 1 | Output cell is a monitoring cell |

## Verification
The bench builds the block with a small configuration:

| Parameter | Bench value |
|---|---|
| `BLOCK_CELLS` | 4 |
| `PAY_BYTES` | 10 (five parity words and 51 padding bits) |
| `CNT_W` | 5 |
| `TS_W` | 8 |

With these values, the count field wraps after eight blocks and the timestamp wraps within the run. This brings both modulo boundaries within reach, along with the zero padding check.

The bench sweeps every pairing of four upstream-valid patterns with four downstream-ready patterns. That covers insertion with a free output slot, insertion behind a stalled output, and a monitoring cell handed off in the same cycle a user cell is accepted.

// File: rtl/atm_fm_inserter.sv
module atm_fm_inserter #(
  parameter int PAY_BYTES   = 48,
  parameter int BLOCK_CELLS = 512,
  parameter int CNT_W       = 16,
  parameter int TS_W        = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PAY_BYTES*8-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PAY_BYTES*8-1:0] out_data,
  output logic                   out_mon
);
  localparam int PAY_W  = PAY_BYTES * 8;
  localparam int PW     = 16;
  localparam int NWORDS = PAY_W / PW;
  localparam int BLK_W  = $clog2(BLOCK_CELLS);

  logic [BLK_W-1:0] blk_q;
  logic             pend_q;
  logic [CNT_W-1:0] tuc_q;
  logic [TS_W-1:0]  ts_q;
  logic [PW-1:0]    par_q, cell_par;
  logic [PAY_W-1:0] mon_cell, data_q;
  logic             valid_q, mon_q;

  wire slot_free = !valid_q || out_ready;
  wire take      = in_valid && in_ready;
  wire blk_last  = blk_q == BLK_W'(BLOCK_CELLS - 1);
  wire emit_mon  = pend_q && slot_free;

  assign in_ready  = slot_free && !pend_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_mon   = mon_q;

  always_comb begin
    cell_par = '0;
    for (int w = 0; w < NWORDS; w++) cell_par = cell_par ^ in_data[w*PW +: PW];
  end

  always_comb begin
    mon_cell = '0;
    mon_cell[CNT_W-1:0]          = tuc_q;
    mon_cell[CNT_W +: TS_W]      = ts_q;
    mon_cell[CNT_W+TS_W +: PW]   = par_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q   <= '0;
      tuc_q  <= '0;
      par_q  <= '0;
      blk_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (take) begin
        tuc_q <= tuc_q + 1'b1;
        par_q <= par_q ^ cell_par;
        blk_q <= blk_last ? '0 : blk_q + 1'b1;
        if (blk_last) pend_q <= 1'b1;
      end
      if (emit_mon) begin
        pend_q <= 1'b0;
        par_q  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mon_q   <= 1'b0;
      data_q  <= '0;
    end else if (emit_mon) begin
      valid_q <= 1'b1;
      mon_q   <= 1'b1;
      data_q  <= mon_cell;
    end else if (slot_free) begin
      valid_q <= take;
      mon_q   <= 1'b0;
      if (take) data_q <= in_data;
    end
  end
endmodule

module atm_fm_inserter_chk #(
  parameter int PAY_BYTES   = 48,
  parameter int BLOCK_CELLS = 512,
  parameter int CNT_W       = 16,
  parameter int TS_W        = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [PAY_BYTES*8-1:0] in_data,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [PAY_BYTES*8-1:0] out_data,
  input logic                   out_mon
);
  localparam int CW = $clog2(BLOCK_CELLS) + 2;

  logic [CW-1:0]    emit_cnt, acc_cnt;
  logic [CNT_W-1:0] last_tuc;
  logic             seen;

  wire out_hs = out_valid && out_ready;
  wire mon_hs = out_hs && out_mon;
  wire in_hs  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      emit_cnt <= '0;
      acc_cnt  <= '0;
      last_tuc <= '0;
      seen     <= 1'b0;
    end else begin
      if (mon_hs) emit_cnt <= '0;
      else if (out_hs) emit_cnt <= emit_cnt + 1'b1;
      if (mon_hs) acc_cnt <= CW'(in_hs);
      else if (in_hs) acc_cnt <= acc_cnt + 1'b1;
      if (mon_hs) begin
        last_tuc <= out_data[CNT_W-1:0];
        seen     <= 1'b1;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mon)); // R8
  AST_MON_AT_BLOCK_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mon |-> emit_cnt == CW'(BLOCK_CELLS)); // R3
  AST_USER_WITHIN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_mon |-> emit_cnt < CW'(BLOCK_CELLS)); // R3
  AST_STALL_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    acc_cnt == CW'(BLOCK_CELLS) && !(out_valid && out_mon) |-> !in_ready); // R7
  AST_TUC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mon && seen |-> out_data[CNT_W-1:0] == CNT_W'(last_tuc + CNT_W'(BLOCK_CELLS))); // R4
endmodule

bind atm_fm_inserter atm_fm_inserter_chk #(
  .PAY_BYTES(PAY_BYTES), .BLOCK_CELLS(BLOCK_CELLS), .CNT_W(CNT_W), .TS_W(TS_W)
) u_chk (.*);

// File: tb/test_atm_fm_inserter.sv
module test_atm_fm_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int BLK = 4;
  localparam int PB  = 10;
  localparam int CW  = 5;
  localparam int TW  = 8;
  localparam int PW  = PB * 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, out_mon;
  logic [PW-1:0] in_data = '0, out_data;

  atm_fm_inserter #(.PAY_BYTES(PB), .BLOCK_CELLS(BLK), .CNT_W(CW), .TS_W(TW)) i_atm_fm_inserter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_mon(out_mon));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic [PW-1:0] q_data[$];
  bit            q_mon[$];
  int            acc = 0, seq = 0, run = 0, mons = 0;
  logic [CW-1:0] m_tuc = '0;
  logic [15:0]   m_par = '0;
  logic          prev_stall = 0, prev_monvis = 0, prev_mon = 0;
  logic [PW-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] mkdata(input int s);
    logic [15:0] v = 16'(s);
    return {16'(v*3+1), v ^ 16'ha5c3, ~v, 16'(v*v), 16'(v + 16'h1234)};
  endfunction

  function automatic logic [15:0] par(input logic [PW-1:0] d);
    logic [15:0] p = '0;
    for (int w = 0; w < PW/16; w++) p = p ^ d[w*16 +: 16];
    return p;
  endfunction

  function automatic bit pat(input int p, input int t);
    case (p)
      0: return 1'b1;
      1: return t[0];
      2: return (t % 3) != 0;
      3: return ((t * 37 + 11) % 7) < 4;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input int ivp, input int orp, input int t);
    logic [PW-1:0] e;
    bit em;
    @(negedge clk);
    out_ready = pat(orp, t);
    in_valid  = pat(ivp, t);
    in_data   = mkdata(seq);
    #1;
    if (prev_stall)
      chk(out_valid && out_data == prev_data && out_mon == prev_mon, "R8", out_data, prev_data);
    if (out_valid && out_mon && !prev_monvis)
      chk(out_data[CW +: TW] == TW'(cyc - 1), "R6", PW'(out_data[CW +: TW]), PW'(TW'(cyc - 1)));
    if (out_valid && out_ready) begin
      if (q_data.size() == 0) chk(1'b0, "R3", PW'(out_mon), '0);
      else begin
        e  = q_data.pop_front();
        em = q_mon.pop_front();
        chk(out_mon == em, "R3", PW'(out_mon), PW'(em));
        if (em && out_mon) begin
          chk(out_data[CW-1:0] == e[CW-1:0], "R4", PW'(out_data[CW-1:0]), PW'(e[CW-1:0]));
          chk(out_data[CW+TW +: 16] == e[CW+TW +: 16], "R5", PW'(out_data[CW+TW +: 16]), PW'(e[CW+TW +: 16]));
          chk((out_data >> (CW+TW+16)) == '0, "R9", out_data >> (CW+TW+16), '0);
        end else if (!em)
          chk(out_data == e, "R2", out_data, e);
      end
    end
    if (orp == 0) begin
      if (!in_ready) run++;
      else if (run > 0) begin
        chk(run == 1, "R7", PW'(run), PW'(1));
        run = 0;
      end
    end else run = 0;
    if (in_valid && in_ready) begin
      q_data.push_back(in_data);
      q_mon.push_back(1'b0);
      m_tuc = m_tuc + 1'b1;
      m_par = m_par ^ par(in_data);
      seq++;
      acc++;
      if (acc == BLK) begin
        e = '0;
        e[CW-1:0] = m_tuc;
        e[CW+TW +: 16] = m_par;
        q_data.push_back(e);
        q_mon.push_back(1'b1);
        acc = 0;
        m_par = '0;
        mons++;
      end
    end
    prev_stall  = out_valid && !out_ready;
    prev_monvis = out_valid && out_mon && !out_ready;
    prev_data   = out_data;
    prev_mon    = out_mon;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1", PW'({out_valid, in_ready}), PW'(2'b01));
    rst_n = 1;
    #1;
    chk(!out_valid && in_ready, "R1", PW'({out_valid, in_ready}), PW'(2'b01));
    for (int iv = 0; iv < 4; iv++)
      for (int orp = 0; orp < 4; orp++)
        for (int t = 0; t < 48; t++) step(iv, orp, t);
    for (int t = 0; t < 24; t++) step(4, 0, t);
    chk(q_data.size() == 0, "R3", PW'(q_data.size()), '0);
    chk(mons > 2 * (1 << CW) / BLK, "R4", PW'(mons), PW'(2 * (1 << CW) / BLK));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule